// File: doc/BRIEF.md
# Fractional Clock Divider with Crystal Bypass

This block derives a memory-interface clock from a fast reference clock. It works entirely in the reference domain and produces a clock enable: one cycle high for each edge of the derived clock. A pulse-swallowing stage keeps 18 out of every N reference cycles. An integer stage then divides those surviving pulses by D, so the derived rate is reference × 18 / (N × D). Settings of N = 19 with D = 3, N = 33 with D = 2 and N = 27 with D = 5 turn a 480 MHz reference into roughly 151.6, 130.9 and 64 MHz. Each stage has its own gate input, and a low gate lets that stage run.

The crystal clock arrives as a one-cycle tick already synchronous to the reference. A bypass select moves the output between the divided clock and the crystal ticks through a handshake that never emits a shortened or doubled pulse. Leaving the divided clock stops its pulses at once. The output then waits for a crystal tick, which is swallowed, and after that it follows the crystal. Returning works the same way with the first divided pulse swallowed. A busy flag in each direction shows that a move is still open. The divider settings are taken only while the output sits on the crystal. Software changes N and D there and then clears bypass to use the new values.

Top module: `clkfd_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, clk_en_o, busy_xtal_o and busy_ref_o are 0. Reset leaves the output on the crystal source.
- R2: With both gates low and the output on the divided clock, every window of N×D consecutive cycles holds exactly 18 clk_en_o pulses. The fractional stage keeps 18 of every N reference cycles: a phase value gains 18 per cycle, and a pulse is kept when the sum reaches N. N is then subtracted.
- R3: An N below 18 (0 included) acts as 18, so every reference cycle is kept.
- R4: The integer stage emits one pulse per D kept pulses. A D of 0 acts as 1.
- R5: While frac_gate_i is 1, no pulse is kept and the phase value holds. On release, the sequence resumes where it stopped.
- R6: While div_gate_i is 1, the integer stage emits nothing and its count holds. The phase value keeps running.
- R7: If bypass_i is 1 while the output is on the divided clock, busy_xtal_o is 1 from the next cycle. It stays 1 until a cycle with xtal_tick_i high, and that tick is not forwarded. From then on, clk_en_o repeats xtal_tick_i one cycle late.
- R8: If bypass_i is 0 while the output is on the crystal, busy_ref_o is 1 from the next cycle. It stays 1 until the divided clock produces a pulse, and that pulse is not forwarded. From then on, clk_en_o repeats the divided pulses one cycle late.
- R9: N and D are sampled only while the output is on the crystal. Changes made at other times have no effect until the next return from the crystal.
- R10: Both divider stages are cleared while the output is on the crystal or moving to it. Each return starts from a phase of 0 and a count of 0.
- R11: The two busy flags are never 1 together, and clk_en_o is 0 in the cycle after any busy flag is 1.
- R12: A move that has begun always completes before bypass_i is looked at again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xtal_tick_i | input | 1 | One pulse per crystal clock edge, synchronous to clk_i |
| frac_n_i | input | FRAC_W (6) | Fractional value N |
| div_d_i | input | DIV_W (8) | Integer divide value D |
| frac_gate_i | input | 1 | 1 stops the fractional stage |
| div_gate_i | input | 1 | 1 stops the integer stage |
| bypass_i | input | 1 | 1 selects the crystal, 0 the divided clock |
| clk_en_o | output | 1 | Enable of the selected output clock |
| busy_xtal_o | output | 1 | Move toward the crystal still in progress |
| busy_ref_o | output | 1 | Move toward the divided clock still in progress |

## Verification
Two pairs of events can land in the same cycle. In the first, a bypass request arrives in the same cycle as a divided pulse, or a move is still open when bypass_i flips back. In the second, a gate changes in the cycle a move toward the divided clock is waiting for its first pulse. The bench causes these by raising bypass for a single cycle and by toggling the gates around the return to the divided clock. A behavioural model that advances once per clock judges the result by comparing clk_en_o and both busy flags on every cycle. Fixed windows also count pulses against the 18-per-N×D rate.

// File: rtl/clkfd_pkg.sv
package clkfd_pkg;
  typedef enum logic [1:0] {
    SRC_XTAL = 2'd0,
    SRC_TO_REF = 2'd1,
    SRC_REF = 2'd2,
    SRC_TO_XTAL = 2'd3
  } src_state_e;

  localparam int unsigned KEEP_PER_N = 18;
endpackage

// File: rtl/clkfd_frac_stage.sv
module clkfd_frac_stage #(
  parameter int unsigned FRAC_W = 6,
  parameter int unsigned KEEP = clkfd_pkg::KEEP_PER_N
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              gate_i,
  input  logic [FRAC_W-1:0] n_i,
  output logic              pulse_o
);
  localparam int unsigned SUM_W = FRAC_W + 2;

  logic [SUM_W-1:0] phase_q;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] n_ext;

  assign n_ext   = SUM_W'(n_i);
  assign sum     = phase_q + SUM_W'(KEEP);
  assign pulse_o = run_i && !gate_i && (sum >= n_ext);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
    end else if (!run_i) begin
      phase_q <= '0;
    end else if (!gate_i) begin
      phase_q <= pulse_o ? (sum - n_ext) : sum;
    end
  end
endmodule

// File: rtl/clkfd_int_stage.sv
module clkfd_int_stage #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             gate_i,
  input  logic             pulse_i,
  input  logic [DIV_W-1:0] d_i,
  output logic             pulse_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             last;

  assign last    = (cnt_q == d_i - DIV_W'(1));
  assign pulse_o = run_i && !gate_i && pulse_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
    end else if (pulse_i && !gate_i) begin
      cnt_q <= last ? '0 : cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/clkfd_switch.sv
module clkfd_switch
  import clkfd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bypass_i,
  input  logic xtal_tick_i,
  input  logic div_pulse_i,
  output logic run_o,
  output logic load_o,
  output logic clk_en_o,
  output logic busy_xtal_o,
  output logic busy_ref_o
);
  src_state_e state_q, state_d;
  logic       ce_q, ce_d;

  always_comb begin
    state_d = state_q;
    ce_d    = 1'b0;
    unique case (state_q)
      SRC_XTAL: begin
        ce_d = xtal_tick_i;
        if (!bypass_i) state_d = SRC_TO_REF;
      end
      SRC_TO_REF: begin
        if (div_pulse_i) state_d = SRC_REF;
      end
      SRC_REF: begin
        ce_d = div_pulse_i;
        if (bypass_i) state_d = SRC_TO_XTAL;
      end
      SRC_TO_XTAL: begin
        if (xtal_tick_i) state_d = SRC_XTAL;
      end
      default: state_d = SRC_XTAL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SRC_XTAL;
      ce_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      ce_q    <= ce_d;
    end
  end

  assign run_o       = (state_q == SRC_TO_REF) || (state_q == SRC_REF);
  assign load_o      = (state_q == SRC_XTAL);
  assign clk_en_o    = ce_q;
  assign busy_xtal_o = (state_q == SRC_TO_XTAL);
  assign busy_ref_o  = (state_q == SRC_TO_REF);
endmodule

// File: rtl/clkfd_top.sv
module clkfd_top #(
  parameter int unsigned FRAC_W = 6,
  parameter int unsigned DIV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xtal_tick_i,
  input  logic [FRAC_W-1:0] frac_n_i,
  input  logic [DIV_W-1:0]  div_d_i,
  input  logic              frac_gate_i,
  input  logic              div_gate_i,
  input  logic              bypass_i,
  output logic              clk_en_o,
  output logic              busy_xtal_o,
  output logic              busy_ref_o
);
  localparam int unsigned KEEP = clkfd_pkg::KEEP_PER_N;
  localparam logic [FRAC_W-1:0] N_MIN = FRAC_W'(KEEP);
  localparam logic [DIV_W-1:0] D_MIN = DIV_W'(1);

  logic [FRAC_W-1:0] n_q;
  logic [DIV_W-1:0]  d_q;
  logic              run, load, frac_pulse, div_pulse;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q <= N_MIN;
      d_q <= D_MIN;
    end else if (load) begin
      n_q <= (frac_n_i < N_MIN) ? N_MIN : frac_n_i;
      d_q <= (div_d_i == '0) ? D_MIN : div_d_i;
    end
  end

  clkfd_frac_stage #(.FRAC_W(FRAC_W), .KEEP(KEEP)) frac_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .gate_i(frac_gate_i),
    .n_i(n_q), .pulse_o(frac_pulse)
  );

  clkfd_int_stage #(.DIV_W(DIV_W)) int_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .gate_i(div_gate_i),
    .pulse_i(frac_pulse), .d_i(d_q), .pulse_o(div_pulse)
  );

  clkfd_switch sw_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .bypass_i(bypass_i),
    .xtal_tick_i(xtal_tick_i), .div_pulse_i(div_pulse),
    .run_o(run), .load_o(load), .clk_en_o(clk_en_o),
    .busy_xtal_o(busy_xtal_o), .busy_ref_o(busy_ref_o)
  );
endmodule

// File: rtl/clkfd_checker.sv
module clkfd_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic bypass_i,
  input logic xtal_tick_i,
  input logic clk_en_o,
  input logic busy_xtal_o,
  input logic busy_ref_o,
  input logic div_pulse
);
  // R11: the busy flags exclude each other
  a_r11_busy_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_xtal_o && busy_ref_o));

  // R11: nothing is forwarded after a busy cycle
  a_r11_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_xtal_o || busy_ref_o) |=> !clk_en_o);

  // R7: a move to the crystal starts only on request
  a_r7_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_xtal_o) |-> $past(bypass_i));

  // R7: busy toward the crystal holds until a tick
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_xtal_o && !xtal_tick_i) |=> busy_xtal_o);

  // R7: a tick completes the move
  a_r7_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_xtal_o && xtal_tick_i) |=> !busy_xtal_o);

  // R8: the first divided pulse completes the move back
  a_r8_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_ref_o && div_pulse) |=> !busy_ref_o);

  // R8: busy toward the reference holds until a divided pulse
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_ref_o && !div_pulse) |=> busy_ref_o);
endmodule

bind clkfd_top clkfd_checker chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .bypass_i(bypass_i),
  .xtal_tick_i(xtal_tick_i), .clk_en_o(clk_en_o),
  .busy_xtal_o(busy_xtal_o), .busy_ref_o(busy_ref_o),
  .div_pulse(div_pulse)
);

// File: tb/clkfd_top_tb_top.sv
module clkfd_top_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int FRAC_W = 6;
  localparam int DIV_W = 8;
  localparam int XTAL_EVERY = 7;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xtal_tick = 1'b0;
  logic [FRAC_W-1:0] frac_n = 6'd18;
  logic [DIV_W-1:0] div_d = 8'd1;
  logic frac_gate = 1'b0;
  logic div_gate = 1'b0;
  logic bypass = 1'b1;
  logic clk_en, busy_x, busy_r;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pulses = 0;
  string req = "R1";

  // model state: 0 crystal, 1 to-ref, 2 ref, 3 to-crystal
  int ms = 0, acc = 0, cnt = 0, an = 18, ad = 1;
  bit e_ce = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkfd_top #(.FRAC_W(FRAC_W), .DIV_W(DIV_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .xtal_tick_i(xtal_tick),
    .frac_n_i(frac_n), .div_d_i(div_d), .frac_gate_i(frac_gate),
    .div_gate_i(div_gate), .bypass_i(bypass), .clk_en_o(clk_en),
    .busy_xtal_o(busy_x), .busy_ref_o(busy_r)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; acc = 0; cnt = 0; an = 18; ad = 1; e_ce = 0;
    end else begin
      bit run, fp, dp;
      int nms;
      run = (ms == 1) || (ms == 2);
      fp = run && !frac_gate && (acc + 18 >= an);
      dp = fp && !div_gate && (cnt == ad - 1);
      e_ce = (ms == 2 && dp) || (ms == 0 && xtal_tick);
      nms = ms;
      case (ms)
        0: if (!bypass) nms = 1;
        1: if (dp) nms = 2;
        2: if (bypass) nms = 3;
        default: if (xtal_tick) nms = 0;
      endcase
      if (!run) begin acc = 0; cnt = 0; end
      else begin
        if (!frac_gate) acc = fp ? acc + 18 - an : acc + 18;
        if (fp && !div_gate) cnt = dp ? 0 : cnt + 1;
      end
      if (ms == 0) begin
        an = (frac_n < 18) ? 18 : int'(frac_n);
        ad = (div_d == 0) ? 1 : int'(div_d);
      end
      ms = nms;
    end
  end

  task automatic check(input string r, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", r, what, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model, then crystal tick drive
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check(req, int'(clk_en), int'(e_ce), "clk_en_o");
      check(req, int'(busy_x), int'(ms == 3), "busy_xtal_o");
      check(req, int'(busy_r), int'(ms == 1), "busy_ref_o");
      check("R11", int'(busy_x && busy_r), 0, "busy overlap");
      if (clk_en) pulses++;
    end
    xtal_tick <= (cyc % XTAL_EVERY == 0);
    if (cyc > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_state(input int s);
    for (int i = 0; i < 1000 && ms != s; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic window(input string r, input int n, input int exp);
    int base;
    base = pulses;
    step(n);
    check(r, pulses - base, exp, "pulses in window");
  endtask

  task automatic set_and_return(input int n, input int d);
    bypass = 1'b1;
    wait_state(0);
    frac_n = FRAC_W'(n);
    div_d = DIV_W'(d);
    step(2);
    bypass = 1'b0;
    wait_state(2);
  endtask

  initial begin
    req = "R1";
    step(3);
    check("R1", int'(clk_en), 0, "clk_en_o in reset");
    check("R1", int'(busy_x), 0, "busy_xtal_o in reset");
    check("R1", int'(busy_r), 0, "busy_ref_o in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(busy_x || busy_r), 0, "busy after reset");
    frac_n = 6'd19; div_d = 8'd3;
    step(4);

    req = "R8";
    bypass = 1'b0;
    @(negedge clk);
    check("R8", int'(busy_r), 1, "busy_ref_o after bypass clear");
    wait_state(2);
    req = "R2";
    window("R2", 19 * 3, 18);

    req = "R9";
    frac_n = 6'd33; div_d = 8'd2;
    window("R9", 19 * 3, 18);

    req = "R7";
    bypass = 1'b1;
    @(negedge clk);
    check("R7", int'(busy_x), 1, "busy_xtal_o after bypass set");
    wait_state(0);
    window("R7", XTAL_EVERY * 10, 10);

    req = "R10";
    bypass = 1'b0;
    wait_state(2);
    window("R4", 33 * 2, 18);

    req = "R3";
    set_and_return(5, 0);
    window("R3", 10, 10);
    req = "R4";
    set_and_return(27, 5);
    window("R4", 27 * 5, 18);

    req = "R5";
    frac_gate = 1'b1;
    window("R5", 30, 0);
    frac_gate = 1'b0;
    step(7);
    req = "R6";
    div_gate = 1'b1;
    window("R6", 30, 0);
    div_gate = 1'b0;
    step(20);

    req = "R12";
    bypass = 1'b1;
    @(negedge clk);
    bypass = 1'b0;
    @(negedge clk);
    check("R12", int'(busy_x), 1, "move to crystal still open");
    wait_state(2);
    bypass = 1'b1;
    step(3);
    bypass = 1'b0;
    wait_state(2);
    window("R12", 27 * 5, 18);

    req = "R8";
    bypass = 1'b1;
    wait_state(0);
    frac_gate = 1'b1;
    bypass = 1'b0;
    step(20);
    check("R8", int'(busy_r), 1, "busy_ref_o waits while gated");
    frac_gate = 1'b0;
    wait_state(2);
    window("R8", 27 * 5, 18);

    step(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule